// File: doc/BRIEF.md
# Address-space-tagged translation lookaside buffer

This block is a small fully associative cache of page-to-frame translations that sits in front of a page table held in memory. Each cycle it can take one lookup: a virtual page number, the identifier of the running address space and the kind of access. All entries are compared in parallel. One cycle later it reports one of three outcomes. A hit carries the frame number. A protection fault means the entry exists but forbids the access. A refill request names the missing page and identifier so that an external table walker can fetch the translation.

Because every entry is tagged with an address-space identifier, translations of several processes can be held at the same time and a context switch needs no flush. The walker returns its result through the fill port, and the block installs it. A free slot is used first. When the table is full, a round-robin pointer picks the victim. A fill for a page and identifier already held overwrites that entry in place. Software can clear all entries of one identifier, or clear the whole table in a single cycle.

Top module: `asid_tlb`

## Requirements
- R1: After reset no entry is valid: every lookup misses, and no response is raised while no lookup is issued.
- R2: A lookup presented at a clock edge gives `rsp_valid` high for exactly the following cycle. On a hit, `rsp_pfn` is the frame stored with the entry whose page number and identifier both match.
- R3: An entry whose stored identifier differs from the lookup identifier never hits, even when its page number matches.
- R4: A lookup with no matching valid entry raises `refill_req` together with the response and returns the looked-up page and identifier on `refill_vpn`/`refill_asid`. `rsp_hit`, `rsp_fault` and `rsp_pfn` are then zero.
- R5: The permission field has bit 0 = write allowed and bit 1 = fetch allowed; reading is always allowed. The access kind is coded 00 read, 01 write, 10 fetch, and 11 is treated as read. A matching entry that forbids the access gives `rsp_fault`=1 with `rsp_hit`=0, `rsp_pfn`=0 and no refill request.
- R6: A fill of a pair that is not present is written into the lowest-numbered invalid slot when one exists, and the replacement pointer does not move.
- R7: When all slots are valid, a new fill replaces the slot named by the replacement pointer. The pointer starts at 0 after reset, advances by one after each such replacement, wraps after the last slot, and is not changed by flushes.
- R8: A fill of a page/identifier pair that is already present overwrites that entry's frame and permissions. It uses no other slot and does not move the pointer.
- R9: A flush by identifier invalidates exactly the entries tagged with that identifier in one cycle. All other entries keep their translations.
- R10: A global flush invalidates every entry in one cycle. A global flush or a flush by identifier in the same cycle as a fill causes the fill to be ignored.
- R11: A fill with `fill_ok`=0 invalidates the matching entry if the pair is present, and otherwise changes nothing.
- R12: A lookup in the same cycle as a fill or flush is answered from the table contents before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vpn | input | VPN_W (20) | Virtual page number to translate |
| lk_asid | input | ASID_W (8) | Identifier of the current address space |
| lk_kind | input | 2 | Access kind: 00 read, 01 write, 10 fetch |
| rsp_valid | output | 1 | Response to the lookup of the previous cycle |
| rsp_hit | output | 1 | Translation found and access allowed |
| rsp_fault | output | 1 | Translation found but access forbidden |
| rsp_pfn | output | PFN_W (16) | Frame number on a hit, else zero |
| refill_req | output | 1 | Miss: translation must be fetched |
| refill_vpn | output | VPN_W (20) | Page number that missed |
| refill_asid | output | ASID_W (8) | Identifier of the miss |
| fill_valid | input | 1 | Fill from the table walker this cycle |
| fill_vpn | input | VPN_W (20) | Page number of the fill |
| fill_asid | input | ASID_W (8) | Identifier of the fill |
| fill_pfn | input | PFN_W (16) | Frame number of the fill |
| fill_perm | input | 2 | Permissions: bit0 write, bit1 fetch |
| fill_ok | input | 1 | 1 installs the entry, 0 removes the pair |
| flush_one | input | 1 | Invalidate entries of `flush_asid` |
| flush_asid | input | ASID_W (8) | Identifier to flush |
| flush_all | input | 1 | Invalidate every entry |

## Verification
Every lookup outcome (hit, fault or refill request, with its frame, page and identifier) is due in the cycle after the edge that accepted the lookup. Fills and flushes change the table at that same edge, so only a lookup issued in a later cycle sees their effect. The bench drives all inputs on the falling edge. From the table contents before the edge, its model predicts the response that the next rising edge must produce, and then applies the updates. Each response is compared on the next falling edge. Replacement order, free-slot preference and in-place overwrite are never read from inside the design. They show up as later hits and misses across sweeps of every page and identifier used.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  // permission bit 0: store allowed, bit 1: instruction fetch allowed
  function automatic logic access_allowed(input logic [1:0] perm, input logic [1:0] kind);
    logic ok;
    case (acc_e'(kind))
      ACC_WRITE: ok = perm[0];
      ACC_FETCH: ok = perm[1];
      default:   ok = 1'b1;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/tlb_cam.sv
`timescale 1ns/1ps
module tlb_cam #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8
) (
  input  logic [ENTRIES-1:0]             ent_v,
  input  logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn,
  input  logic [ENTRIES-1:0][ASID_W-1:0] ent_asid,
  input  logic [VPN_W-1:0]               key_vpn,
  input  logic [ASID_W-1:0]              key_asid,
  output logic [ENTRIES-1:0]             hits
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hits[g] = ent_v[g] && (ent_vpn[g] == key_vpn) && (ent_asid[g] == key_asid);
  end

endmodule

// File: rtl/tlb_victim.sv
`timescale 1ns/1ps
module tlb_victim #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] ent_v,
  input  logic [IDX_W-1:0]   rr_ptr,
  output logic [IDX_W-1:0]   victim,
  output logic               has_free
);

  logic [IDX_W-1:0] free_idx;

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!ent_v[i]) free_idx = IDX_W'(i);
    end
  end

  assign has_free = ~&ent_v;
  assign victim   = has_free ? free_idx : rr_ptr;

endmodule

// File: rtl/asid_tlb.sv
`timescale 1ns/1ps
module asid_tlb #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 16,
  parameter int ASID_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [1:0]        lk_kind,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_fault,
  output logic [PFN_W-1:0]  rsp_pfn,
  output logic              refill_req,
  output logic [VPN_W-1:0]  refill_vpn,
  output logic [ASID_W-1:0] refill_asid,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [1:0]        fill_perm,
  input  logic              fill_ok,
  input  logic              flush_one,
  input  logic [ASID_W-1:0] flush_asid,
  input  logic              flush_all
);

  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0]             ent_v;
  logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn;
  logic [ENTRIES-1:0][ASID_W-1:0] ent_asid;
  logic [ENTRIES-1:0][PFN_W-1:0]  ent_pfn;
  logic [ENTRIES-1:0][1:0]        ent_perm;
  logic [IDX_W-1:0]               rr_ptr;

  // named internal events, observed by the assertions below
  logic [ENTRIES-1:0] lk_match, fl_match;
  logic               lk_any, lk_allowed;
  logic               evt_hit, evt_fault, evt_miss;
  logic               fill_go, fill_present;
  logic               evt_install, evt_overwrite, evt_remove, evt_evict;
  logic [IDX_W-1:0]   fl_idx, victim, wr_idx;
  logic               has_free;
  logic [PFN_W-1:0]   sel_pfn;
  logic [1:0]         sel_perm;

  function automatic logic [IDX_W-1:0] first_set(input logic [ENTRIES-1:0] vec);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
    return idx;
  endfunction

  tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_cam (
    .ent_v(ent_v), .ent_vpn(ent_vpn), .ent_asid(ent_asid),
    .key_vpn(lk_vpn), .key_asid(lk_asid), .hits(lk_match)
  );

  tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_fl_cam (
    .ent_v(ent_v), .ent_vpn(ent_vpn), .ent_asid(ent_asid),
    .key_vpn(fill_vpn), .key_asid(fill_asid), .hits(fl_match)
  );

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .ent_v(ent_v), .rr_ptr(rr_ptr), .victim(victim), .has_free(has_free)
  );

  always_comb begin
    sel_pfn  = '0;
    sel_perm = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) begin
        sel_pfn  = sel_pfn | ent_pfn[i];
        sel_perm = sel_perm | ent_perm[i];
      end
    end
  end

  assign lk_any     = |lk_match;
  assign lk_allowed = tlb_pkg::access_allowed(sel_perm, lk_kind);
  assign evt_hit    = lk_valid && lk_any && lk_allowed;
  assign evt_fault  = lk_valid && lk_any && !lk_allowed;
  assign evt_miss   = lk_valid && !lk_any;

  assign fill_go       = fill_valid && !flush_all && !flush_one;
  assign fill_present  = |fl_match;
  assign fl_idx        = first_set(fl_match);
  assign evt_overwrite = fill_go && fill_ok && fill_present;
  assign evt_remove    = fill_go && !fill_ok && fill_present;
  assign evt_install   = fill_go && fill_ok && !fill_present;
  assign evt_evict     = evt_install && !has_free;
  assign wr_idx        = fill_present ? fl_idx : victim;

  // valid bits and replacement pointer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_v  <= '0;
      rr_ptr <= '0;
    end else begin
      if (flush_all) begin
        ent_v <= '0;
      end else if (flush_one) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (ent_asid[i] == flush_asid) ent_v[i] <= 1'b0;
        end
      end else if (evt_remove) begin
        ent_v[fl_idx] <= 1'b0;
      end else if (evt_install || evt_overwrite) begin
        ent_v[wr_idx] <= 1'b1;
      end
      if (evt_evict) rr_ptr <= (rr_ptr == LAST_IDX) ? '0 : rr_ptr + 1'b1;
    end
  end

  // entry payload, qualified by the valid bits
  always_ff @(posedge clk) begin
    if (evt_install || evt_overwrite) begin
      ent_vpn[wr_idx]  <= fill_vpn;
      ent_asid[wr_idx] <= fill_asid;
      ent_pfn[wr_idx]  <= fill_pfn;
      ent_perm[wr_idx] <= fill_perm;
    end
  end

  // registered response
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_fault   <= 1'b0;
      rsp_pfn     <= '0;
      refill_req  <= 1'b0;
      refill_vpn  <= '0;
      refill_asid <= '0;
    end else begin
      rsp_valid   <= lk_valid;
      rsp_hit     <= evt_hit;
      rsp_fault   <= evt_fault;
      rsp_pfn     <= evt_hit ? sel_pfn : '0;
      refill_req  <= evt_miss;
      refill_vpn  <= evt_miss ? lk_vpn : '0;
      refill_asid <= evt_miss ? lk_asid : '0;
    end
  end

  a_r2_rsp_follows_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);

  a_r2_no_rsp_without_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid && !rsp_hit && !rsp_fault && !refill_req);

  a_r4_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot({rsp_hit, rsp_fault, refill_req}));

  a_r4_miss_zero_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_req || rsp_fault) |-> rsp_pfn == '0);

  a_r8_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> $onehot0(lk_match));

  a_r6_free_slot_first: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_install && has_free) |-> !ent_v[victim]);

  a_r7_ptr_moves_on_evict: assert property (@(posedge clk) disable iff (!rst_n)
    evt_evict |=> rr_ptr != $past(rr_ptr));

  a_r8_ptr_still_on_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_overwrite || (evt_install && has_free)) |=> $stable(rr_ptr));

  a_r10_global_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> ent_v == '0);

endmodule

// File: tb/asid_tlb_tb_top.sv
`timescale 1ns/1ps
module asid_tlb_tb_top;

  localparam int N  = 16;
  localparam int VW = 20;
  localparam int PW = 16;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          lk_valid = 0, fill_valid = 0, fill_ok = 0, flush_one = 0, flush_all = 0;
  logic [VW-1:0] lk_vpn = '0, fill_vpn = '0;
  logic [AW-1:0] lk_asid = '0, fill_asid = '0, flush_asid = '0;
  logic [1:0]    lk_kind = '0, fill_perm = '0;
  logic [PW-1:0] fill_pfn = '0;
  logic          rsp_valid, rsp_hit, rsp_fault, refill_req;
  logic [PW-1:0] rsp_pfn;
  logic [VW-1:0] refill_vpn;
  logic [AW-1:0] refill_asid;

  asid_tlb #(.ENTRIES(N), .VPN_W(VW), .PFN_W(PW), .ASID_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_kind(lk_kind),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_pfn(rsp_pfn),
    .refill_req(refill_req), .refill_vpn(refill_vpn), .refill_asid(refill_asid),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
    .fill_pfn(fill_pfn), .fill_perm(fill_perm), .fill_ok(fill_ok),
    .flush_one(flush_one), .flush_asid(flush_asid), .flush_all(flush_all)
  );

  int total = 0;
  int bad   = 0;

  // behavioural reference: a list of slots plus a rotating pointer
  bit          m_v    [N];
  int unsigned m_vpn  [N];
  int unsigned m_asid [N];
  int unsigned m_pfn  [N];
  int unsigned m_perm [N];
  int          m_ptr = 0;

  // expected response for the next compare
  bit          x_valid, x_hit, x_fault, x_miss;
  int unsigned x_pfn, x_rvpn, x_rasid;
  string       x_tag = "R1";
  string       s_tag = "R1";

  // staged stimulus for the next tick
  bit          s_lk, s_fill, s_ok, s_fo, s_fa;
  int unsigned s_vpn, s_asid, s_kind, s_fvpn, s_fasid, s_fpfn, s_fperm, s_foasid;

  task automatic check(string what, int unsigned act, int unsigned exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", x_tag, what, act, exp);
    end
  endtask

  function automatic int find_pair(int unsigned vpn, int unsigned asid);
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_vpn[i] == vpn && m_asid[i] == asid) return i;
    return -1;
  endfunction

  task automatic tick();
    int idx;
    @(negedge clk);
    check("rsp_valid", rsp_valid, x_valid);
    check("rsp_hit", rsp_hit, x_hit);
    check("rsp_fault", rsp_fault, x_fault);
    check("rsp_pfn", rsp_pfn, x_pfn);
    check("refill_req", refill_req, x_miss);
    check("refill_vpn", refill_vpn, x_rvpn);
    check("refill_asid", refill_asid, x_rasid);
    lk_valid = s_lk; lk_vpn = VW'(s_vpn); lk_asid = AW'(s_asid); lk_kind = 2'(s_kind);
    fill_valid = s_fill; fill_vpn = VW'(s_fvpn); fill_asid = AW'(s_fasid);
    fill_pfn = PW'(s_fpfn); fill_perm = 2'(s_fperm); fill_ok = s_ok;
    flush_one = s_fo; flush_asid = AW'(s_foasid); flush_all = s_fa;
    // prediction from the contents before the edge (R12)
    x_tag = s_tag;
    x_valid = s_lk; x_hit = 0; x_fault = 0; x_miss = 0; x_pfn = 0; x_rvpn = 0; x_rasid = 0;
    if (s_lk) begin
      idx = find_pair(s_vpn, s_asid);
      if (idx < 0) begin
        x_miss = 1; x_rvpn = s_vpn; x_rasid = s_asid;
      end else if ((s_kind == 1 && m_perm[idx][0] == 0) || (s_kind == 2 && m_perm[idx][1] == 0)) begin
        x_fault = 1;
      end else begin
        x_hit = 1; x_pfn = m_pfn[idx];
      end
    end
    // table update
    if (s_fa) begin
      for (int i = 0; i < N; i++) m_v[i] = 0;
    end else if (s_fo) begin
      for (int i = 0; i < N; i++) if (m_asid[i] == s_foasid) m_v[i] = 0;
    end else if (s_fill) begin
      idx = find_pair(s_fvpn, s_fasid);
      if (idx >= 0) begin
        if (s_ok) begin m_pfn[idx] = s_fpfn; m_perm[idx] = s_fperm; end
        else m_v[idx] = 0;
      end else if (s_ok) begin
        idx = -1;
        for (int i = N - 1; i >= 0; i--) if (!m_v[i]) idx = i;
        if (idx < 0) begin idx = m_ptr; m_ptr = (m_ptr + 1) % N; end
        m_v[idx] = 1; m_vpn[idx] = s_fvpn; m_asid[idx] = s_fasid;
        m_pfn[idx] = s_fpfn; m_perm[idx] = s_fperm;
      end
    end
    s_lk = 0; s_fill = 0; s_fo = 0; s_fa = 0; s_ok = 0;
  endtask

  task automatic stage_lookup(int unsigned vpn, int unsigned asid, int unsigned kind, string tag);
    s_lk = 1; s_vpn = vpn; s_asid = asid; s_kind = kind; s_tag = tag;
  endtask

  task automatic stage_fill(int unsigned vpn, int unsigned asid, int unsigned pfn,
                            int unsigned perm, bit ok);
    s_fill = 1; s_fvpn = vpn; s_fasid = asid; s_fpfn = pfn; s_fperm = perm; s_ok = ok;
  endtask

  task automatic sweep(string tag);
    int unsigned pages [19];
    for (int i = 0; i < 16; i++) pages[i] = 32'h100 + i;
    pages[16] = 32'h500; pages[17] = 32'h501; pages[18] = 32'h600;
    for (int p = 0; p < 19; p++)
      for (int a = 1; a <= 3; a++) begin
        stage_lookup(pages[p], a, 0, tag);
        tick();
      end
  endtask

  initial begin
    #(200000 * 4);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) m_v[i] = 0;
    x_valid = 0; x_hit = 0; x_fault = 0; x_miss = 0; x_pfn = 0; x_rvpn = 0; x_rasid = 0;
    s_lk = 0; s_fill = 0; s_fo = 0; s_fa = 0; s_ok = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick(); tick();                          // R1: quiet outputs after reset
    stage_lookup(32'h10, 1, 0, "R1"); tick();  // R1/R4: empty table misses
    stage_lookup(32'h105, 3, 2, "R4"); tick();
    // R6: fill 16 entries into free slots
    for (int i = 0; i < 16; i++) begin
      stage_fill(32'h100 + i, i % 3 + 1, 32'h200 + i * 3, i % 4, 1); tick();
    end
    sweep("R2");                             // R2 hits, R3 other identifiers miss
    stage_lookup(32'h100, 9, 0, "R3"); tick();
    // R5: permissions for all four codes, write and fetch
    for (int i = 0; i < 4; i++) begin
      stage_lookup(32'h100 + i, i % 3 + 1, 1, "R5"); tick();
      stage_lookup(32'h100 + i, i % 3 + 1, 2, "R5"); tick();
      stage_lookup(32'h100 + i, i % 3 + 1, 3, "R5"); tick();
    end
    // R12 then R8: overwrite with a concurrent lookup of the same pair
    stage_lookup(32'h105, 3, 0, "R12"); stage_fill(32'h105, 3, 32'h7777, 3, 1); tick();
    stage_lookup(32'h105, 3, 1, "R8"); tick();
    // R7: table full, two replacements in pointer order
    stage_fill(32'h500, 1, 32'h5000, 3, 1); tick();
    stage_fill(32'h501, 2, 32'h5010, 0, 1); tick();
    sweep("R7");
    // R11: remove a present pair, then a new fill takes the freed slot (R6)
    stage_fill(32'h103, 1, 0, 0, 0); tick();
    stage_lookup(32'h103, 1, 0, "R11"); tick();
    stage_fill(32'h600, 2, 32'h6000, 1, 1); tick();
    stage_fill(32'h700, 3, 32'h7000, 1, 1); tick();  // evicts next pointer slot
    stage_fill(32'h9999, 1, 0, 0, 0); tick();         // R11: absent pair, no change
    sweep("R6");
    // R10: flush by identifier wins over a same-cycle fill
    s_fo = 1; s_foasid = 2; stage_fill(32'h800, 1, 32'h8000, 3, 1);
    stage_lookup(32'h101, 2, 0, "R12"); tick();
    stage_lookup(32'h800, 1, 0, "R10"); tick();
    sweep("R9");
    // R10: global flush, then the pointer continues (R7)
    s_fa = 1; stage_fill(32'h801, 1, 32'h8010, 3, 1); tick();
    sweep("R10");
    for (int i = 0; i < 17; i++) begin
      stage_fill(32'h100 + i, 1, 32'h300 + i, 3, 1); tick();
    end
    sweep("R7");
    tick();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule